// File: doc/BRIEF.md
# Bidirectional Row-Scan Token Driver

This block is the logic core of a scanned-display row driver. It holds one shift register with a stage for every row. A pulse on the active chain input clears the whole register and places one logic-high token at the head stage. Each later rising clock edge then walks the token one row further. A direction input chooses which chain pin accepts the pulse and which one carries the token out, so the scan can run in either direction. Several devices can be cascaded into one longer scan this way.

Each stage drives one row. The row value passes through a polarity selector, and one shared active-high disable puts every row into high impedance. The bidirectional chain pins and the tristate rows are modelled as a value plus an enable. Level translation and analog drive belong to the surrounding pad ring.

Top module: `row_scan_driver`

## Requirements
- R1: On a rising edge with `rst` high, every stage clears to 0. The chain outputs then read 0, and each row shows the zero-data level (1 when `pol` is 0, 0 when `pol` is 1).
- R2: Forward mode is `dir`=1. On an edge where `chain_a_in` is high and `rst` is low, stage 0 loads 1 and every other stage loads 0.
- R3: In forward mode, each edge with `chain_a_in` low moves the token from stage k to stage k+1. From the last stage the token leaves the register, which is then all zero.
- R4: Reverse mode is `dir`=0. On an edge where `chain_b_in` is high, stage NUM_ROWS-1 loads 1 and every other stage loads 0. Each edge without that pulse moves the token from stage k to stage k-1.
- R5: A chain-input pulse during a scan, including on the edge where the token sits in the end stage, clears the old token and restarts from the head stage.
- R6: When `dir`=1, `chain_b_oe` is 1, `chain_b_out` equals stage NUM_ROWS-1, and `chain_a_oe` and `chain_a_out` are 0. When `dir`=0, `chain_a_oe` is 1, `chain_a_out` equals stage 0, and B is released and reads 0.
- R7: `row_val[i]` equals stage i when `pol` is 1, and its inverse when `pol` is 0. `pol` acts without a clock edge.
- R8: `row_drv_en` is all zeros while `out_dis` is 1 and all ones while it is 0. `out_dis` does not change the stage contents or the shifting.
- R9: The chain pin that is in output mode is ignored as an input. A high `chain_b_in` with `dir`=1 does not restart the scan, and the token still shifts.
- R10: Reset wins over a chain-input pulse on the same edge, and the register becomes all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dir | input | 1 | Scan direction: 1 = A in / B out, 0 = B in / A out |
| chain_a_in | input | 1 | Value sensed on chain pin A |
| chain_b_in | input | 1 | Value sensed on chain pin B |
| pol | input | 1 | Output polarity select |
| out_dis | input | 1 | Global row tristate, active high |
| chain_a_out | output | 1 | Value driven on chain pin A |
| chain_a_oe | output | 1 | Drive enable for chain pin A |
| chain_b_out | output | 1 | Value driven on chain pin B |
| chain_b_oe | output | 1 | Drive enable for chain pin B |
| row_val | output | NUM_ROWS | Logic level for each row output |
| row_drv_en | output | NUM_ROWS | Drive enable for each row output |

## Verification
Injection and the token's exit from the end stage can fall on the same edge. When they do, the chain output and the head stage must change together. The bench provokes this by walking a token into the last stage and holding the chain input high for the next edge. It then expects the head stage set, no token anywhere else, and the chain output back at 0. A second collision is reset against injection on one edge. That case is judged by an all-zero register after the edge.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;

   typedef enum logic {
      SCAN_REV = 1'b0,
      SCAN_FWD = 1'b1
   } scan_dir_e;

   // Index of the stage that receives a fresh token in a given direction.
   function automatic int unsigned head_index(input scan_dir_e d, input int unsigned n);
      return (d == SCAN_FWD) ? 0 : n - 1;
   endfunction

   // Index of the stage whose value leaves the chain in a given direction.
   function automatic int unsigned tail_index(input scan_dir_e d, input int unsigned n);
      return (d == SCAN_FWD) ? n - 1 : 0;
   endfunction

endpackage

// File: rtl/row_chain_port.sv
module row_chain_port
   import row_scan_pkg::*;
(
   input  scan_dir_e dir,
   input  logic      a_in,
   input  logic      b_in,
   input  logic      tail_fwd,
   input  logic      tail_rev,
   output logic      inject,
   output logic      a_out,
   output logic      a_oe,
   output logic      b_out,
   output logic      b_oe
);

   logic fwd;

   assign fwd    = (dir == SCAN_FWD);

   // Only the pin in input mode can start a scan.
   assign inject = fwd ? a_in : b_in;

   // The pin in output mode carries the tail stage. The idle pin is released.
   assign b_oe   = fwd;
   assign a_oe   = ~fwd;
   assign b_out  = fwd  & tail_fwd;
   assign a_out  = ~fwd & tail_rev;

endmodule

// File: rtl/row_token_shifter.sv
module row_token_shifter
   import row_scan_pkg::*;
#(
   parameter int unsigned NUM_ROWS = 40
) (
   input  logic                clk,
   input  logic                rst,
   input  scan_dir_e           dir,
   input  logic                inject,
   output logic [NUM_ROWS-1:0] stage_q
);

   localparam int unsigned LAST = NUM_ROWS - 1;

   if (NUM_ROWS < 2) begin : g_bad_rows
      $error("row_token_shifter: NUM_ROWS must be at least 2");
   end

   logic [NUM_ROWS-1:0] stage_d;
   logic                fwd;

   assign fwd = (dir == SCAN_FWD);

   for (genvar i = 0; i < NUM_ROWS; i++) begin : g_stage
      localparam bit FWD_HEAD = (i == 0);
      localparam bit REV_HEAD = (i == LAST);
      logic from_lower;
      logic from_upper;
      logic seed;

      if (i == 0) begin : g_lo_edge
         assign from_lower = 1'b0;
      end else begin : g_lo_mid
         assign from_lower = stage_q[i-1];
      end

      if (i == LAST) begin : g_hi_edge
         assign from_upper = 1'b0;
      end else begin : g_hi_mid
         assign from_upper = stage_q[i+1];
      end

      assign seed       = fwd ? FWD_HEAD : REV_HEAD;
      assign stage_d[i] = inject ? seed : (fwd ? from_lower : from_upper);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         stage_q <= '0;
      end else begin
         stage_q <= stage_d;
      end
   end

endmodule

// File: rtl/row_output_stage.sv
module row_output_stage #(
   parameter int unsigned NUM_ROWS = 40
) (
   input  logic [NUM_ROWS-1:0] stage_q,
   input  logic                pol,
   input  logic                out_dis,
   output logic [NUM_ROWS-1:0] row_val,
   output logic [NUM_ROWS-1:0] row_drv_en
);

   for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
      // A stored 1 follows the polarity level; a stored 0 takes the opposite level.
      assign row_val[i]    = ~(stage_q[i] ^ pol);
      assign row_drv_en[i] = ~out_dis;
   end

endmodule

// File: rtl/row_scan_driver.sv
module row_scan_driver
   import row_scan_pkg::*;
#(
   parameter int unsigned NUM_ROWS = 40
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                dir,
   input  logic                chain_a_in,
   input  logic                chain_b_in,
   input  logic                pol,
   input  logic                out_dis,
   output logic                chain_a_out,
   output logic                chain_a_oe,
   output logic                chain_b_out,
   output logic                chain_b_oe,
   output logic [NUM_ROWS-1:0] row_val,
   output logic [NUM_ROWS-1:0] row_drv_en
);

   scan_dir_e           dir_e;
   logic                inject;
   logic [NUM_ROWS-1:0] stage_q;

   assign dir_e = scan_dir_e'(dir);

   row_chain_port u_port (
      .dir      (dir_e),
      .a_in     (chain_a_in),
      .b_in     (chain_b_in),
      .tail_fwd (stage_q[NUM_ROWS-1]),
      .tail_rev (stage_q[0]),
      .inject   (inject),
      .a_out    (chain_a_out),
      .a_oe     (chain_a_oe),
      .b_out    (chain_b_out),
      .b_oe     (chain_b_oe)
   );

   row_token_shifter #(.NUM_ROWS(NUM_ROWS)) u_shift (
      .clk     (clk),
      .rst     (rst),
      .dir     (dir_e),
      .inject  (inject),
      .stage_q (stage_q)
   );

   row_output_stage #(.NUM_ROWS(NUM_ROWS)) u_out (
      .stage_q    (stage_q),
      .pol        (pol),
      .out_dis    (out_dis),
      .row_val    (row_val),
      .row_drv_en (row_drv_en)
   );

endmodule

// File: rtl/row_scan_driver_chk.sv
module row_scan_driver_chk #(
   parameter int unsigned NUM_ROWS = 40
) (
   input logic                clk,
   input logic                rst,
   input logic                dir,
   input logic                chain_a_in,
   input logic                chain_b_in,
   input logic                pol,
   input logic                out_dis,
   input logic                chain_a_out,
   input logic                chain_a_oe,
   input logic                chain_b_out,
   input logic                chain_b_oe,
   input logic [NUM_ROWS-1:0] row_val,
   input logic [NUM_ROWS-1:0] row_drv_en
);

   localparam logic [NUM_ROWS-1:0] HEAD_FWD = NUM_ROWS'(1);
   localparam logic [NUM_ROWS-1:0] HEAD_REV = HEAD_FWD << (NUM_ROWS - 1);

   // Stage contents seen from the row pins, with the polarity removed.
   logic [NUM_ROWS-1:0] seen;
   assign seen = pol ? row_val : ~row_val;

   assert_reset_clear_R1: assert property (@(posedge clk) rst |=> seen == '0);

   assert_inject_fwd_R2: assert property (@(posedge clk) disable iff (rst)
      (dir && chain_a_in) |=> seen == HEAD_FWD);

   assert_shift_fwd_R3: assert property (@(posedge clk) disable iff (rst)
      (dir && !chain_a_in) |=> seen == ($past(seen) << 1));

   assert_single_token_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(seen));

   assert_inject_rev_R4: assert property (@(posedge clk) disable iff (rst)
      (!dir && chain_b_in) |=> seen == HEAD_REV);

   assert_shift_rev_R4: assert property (@(posedge clk) disable iff (rst)
      (!dir && !chain_b_in) |=> seen == ($past(seen) >> 1));

   assert_chain_fwd_R6: assert property (@(posedge clk) disable iff (rst)
      dir |-> (chain_b_oe && !chain_a_oe && !chain_a_out && chain_b_out == seen[NUM_ROWS-1]));

   assert_chain_rev_R6: assert property (@(posedge clk) disable iff (rst)
      !dir |-> (chain_a_oe && !chain_b_oe && !chain_b_out && chain_a_out == seen[0]));

   assert_disable_R8: assert property (@(posedge clk) disable iff (rst)
      out_dis |-> row_drv_en == '0);

   assert_enable_R8: assert property (@(posedge clk) disable iff (rst)
      !out_dis |-> &row_drv_en);

endmodule

bind row_scan_driver row_scan_driver_chk #(.NUM_ROWS(NUM_ROWS)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .dir         (dir),
   .chain_a_in  (chain_a_in),
   .chain_b_in  (chain_b_in),
   .pol         (pol),
   .out_dis     (out_dis),
   .chain_a_out (chain_a_out),
   .chain_a_oe  (chain_a_oe),
   .chain_b_out (chain_b_out),
   .chain_b_oe  (chain_b_oe),
   .row_val     (row_val),
   .row_drv_en  (row_drv_en)
);

// File: tb/row_scan_driver_test.sv
module row_scan_driver_test;

   localparam int N = 40;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         dir = 1'b1;
   logic         chain_a_in = 1'b0;
   logic         chain_b_in = 1'b0;
   logic         pol = 1'b1;
   logic         out_dis = 1'b0;
   logic         chain_a_out, chain_a_oe, chain_b_out, chain_b_oe;
   logic [N-1:0] row_val, row_drv_en;

   int vectors = 0;
   int fails   = 0;

   always #5 clk = ~clk;

   row_scan_driver #(.NUM_ROWS(N)) uut (
      .clk         (clk),
      .rst         (rst),
      .dir         (dir),
      .chain_a_in  (chain_a_in),
      .chain_b_in  (chain_b_in),
      .pol         (pol),
      .out_dis     (out_dis),
      .chain_a_out (chain_a_out),
      .chain_a_oe  (chain_a_oe),
      .chain_b_out (chain_b_out),
      .chain_b_oe  (chain_b_oe),
      .row_val     (row_val),
      .row_drv_en  (row_drv_en)
   );

   function automatic logic [N-1:0] tok(input int k);
      logic [N-1:0] one = 1;
      return one << k;
   endfunction

   function automatic logic [N-1:0] rows_for(input logic [N-1:0] d, input logic p);
      return p ? d : ~d;
   endfunction

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_rows(input string req, input logic [N-1:0] d);
      check(req, row_val, rows_for(d, pol));
   endtask

   task automatic do_reset();
      rst = 1'b1; chain_a_in = 1'b0; chain_b_in = 1'b0;
      tick(); tick();
      rst = 1'b0;
   endtask

   task automatic inject_fwd();
      dir = 1'b1; chain_a_in = 1'b1;
      tick();
      chain_a_in = 1'b0;
   endtask

   task automatic inject_rev();
      dir = 1'b0; chain_b_in = 1'b1;
      tick();
      chain_b_in = 1'b0;
   endtask

   task automatic t_reset_state();
      pol = 1'b1; do_reset();
      check_rows("R1 rows zero pol=1", '0);
      check("R1 chain_b_out", N'(chain_b_out), '0);
      pol = 1'b0; #1;
      check_rows("R1 rows zero pol=0", '0);
      pol = 1'b1;
   endtask

   task automatic t_forward_scan();
      do_reset();
      inject_fwd();
      check_rows("R2 head after inject", tok(0));
      for (int k = 1; k < N; k++) begin
         tick();
         check_rows("R3 forward step", tok(k));
         check("R6 chain_b_out fwd", N'(chain_b_out), N'(k == N-1));
      end
      check("R6 fwd oe", {chain_a_oe, chain_b_oe, chain_a_out}, N'(3'b010));
      tick();
      check_rows("R3 token exit", '0);
      check("R3 chain_b_out after exit", N'(chain_b_out), '0);
   endtask

   task automatic t_reverse_scan();
      do_reset();
      inject_rev();
      check_rows("R4 rev head", tok(N-1));
      check("R6 rev oe", {chain_a_oe, chain_b_oe, chain_b_out}, N'(3'b100));
      for (int k = N-2; k >= 0; k--) begin
         tick();
         check_rows("R4 reverse step", tok(k));
         check("R6 chain_a_out rev", N'(chain_a_out), N'(k == 0));
      end
      tick();
      check_rows("R4 reverse exit", '0);
   endtask

   task automatic t_restart_mid();
      do_reset();
      inject_fwd();
      for (int k = 0; k < 10; k++) tick();
      check_rows("R5 before restart", tok(10));
      inject_fwd();
      check_rows("R5 restarted at head", tok(0));
      tick();
      check_rows("R5 continues after restart", tok(1));
   endtask

   task automatic t_exit_collide();
      do_reset();
      inject_fwd();
      for (int k = 1; k < N; k++) tick();
      check("R5 token at tail", N'(chain_b_out), N'(1));
      inject_fwd();
      check_rows("R5 collide restart", tok(0));
      check("R5 collide chain out", N'(chain_b_out), '0);
   endtask

   task automatic t_polarity();
      do_reset();
      inject_fwd(); tick(); tick();
      pol = 1'b0; #1;
      check("R7 pol=0 rows", row_val, ~tok(2));
      pol = 1'b1; #1;
      check("R7 pol=1 rows", row_val, tok(2));
   endtask

   task automatic t_disable();
      do_reset();
      inject_fwd();
      out_dis = 1'b1; #1;
      check("R8 disabled", row_drv_en, '0);
      tick(); tick(); tick();
      check("R8 still disabled", row_drv_en, '0);
      out_dis = 1'b0; #1;
      check("R8 enabled", row_drv_en, '1);
      check_rows("R8 shifting unaffected", tok(3));
   endtask

   task automatic t_ignore_other_pin();
      do_reset();
      inject_fwd();
      chain_b_in = 1'b1;
      tick();
      chain_b_in = 1'b0;
      check_rows("R9 B ignored fwd", tok(1));
      inject_rev();
      chain_a_in = 1'b1;
      tick();
      chain_a_in = 1'b0;
      check_rows("R9 A ignored rev", tok(N-2));
   endtask

   task automatic t_reset_priority();
      do_reset();
      inject_fwd(); tick();
      rst = 1'b1; chain_a_in = 1'b1;
      tick();
      rst = 1'b0; chain_a_in = 1'b0;
      check_rows("R10 reset over inject", '0);
      check("R10 chain out", N'(chain_b_out), '0);
   endtask

   initial begin
      #1;
      t_reset_state();
      t_forward_scan();
      t_reverse_scan();
      t_restart_mid();
      t_exit_collide();
      t_polarity();
      t_disable();
      t_ignore_other_pin();
      t_reset_priority();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule